// File: doc/BRIEF.md
# Secondary Bus Arbiter

This block decides which master owns a shared PCI-style secondary bus. It serves nine external masters, each with an active-low request and grant pair, and the bridge itself as a tenth requester. The inputs are sampled on the bus clock and the grants are driven from it. Ownership rotates in round-robin order. A requester that has just lost its grant must wait out a short gap before it can win again. When nobody asks for the bus, the grant is parked on the bridge. While the bus is idle and the bridge holds the grant, a drive enable tells the bridge to keep the address/data, command/byte-enable and parity lines driven.

A strap input selects the arbitration mode. With the strap low, the block arbitrates by itself. With the strap high, the block assumes an arbiter elsewhere on the board and stops arbitrating. Pair zero is then reused: request input 0 becomes the grant that the bridge receives, and grant output 0 carries the bridge's own request. The block also generates the secondary-bus reset from the primary reset and a software-controlled reset bit. While that reset is active, every grant and the park enable are held off.

Top module: `sbus_arbiter`

## Requirements
- R1: `sec_reset_n` is low in the cycle after any clock edge at which `rst` or `srst_ctl` was sampled high. Otherwise it is high.
- R2: After an edge at which `rst` or `srst_ctl` was high, every `gnt_n` bit is 1, and both `br_gnt` and `park_drive` are 0.
- R3: With the strap low, at most one of {`gnt_n[i]` low, `br_gnt` high} holds at any time.
- R4: Requester indices are as follows: index i (0..8) means `req_n[i]` is low, and index 9 means `br_req` is high. When the grant moves, the search starts at the index after the last one granted and wraps from 9 to 0. The last index is 9 after reset.
- R5: The grant moves only on an edge at which `frame_n` and `irdy_n` are both high (bus idle), or at which the current owner's request is off, or at which nobody owns the bus. Otherwise the grant stays with the current owner.
- R6: If the grant may move and no requester is eligible, the grant parks on the bridge (`br_gnt` high).
- R7: With the strap low, a grant output that turns off stays off for at least 2 clock cycles before it turns on again. A requester that is still inside this gap is skipped by the search.
- R8: With `strap_ext` high, `gnt_n[0]` equals the inverse of `br_req`, and `br_gnt` equals the inverse of `req_n[0]`, each one cycle after sampling. `gnt_n[8:1]` stay high.
- R9: `park_drive` is high in the cycle after an edge at which the bus was idle and the bridge grant is held after that edge. It is low otherwise.
- R10: All grant outputs, `br_gnt`, `park_drive` and `sec_reset_n` are registered and change only at rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Secondary bus clock |
| rst | input | 1 | Primary reset, synchronous, active high |
| srst_ctl | input | 1 | Software secondary-reset control bit |
| strap_ext | input | 1 | Mode strap: 0 selects internal arbitration, 1 selects an external arbiter |
| req_n | input | 9 | Active-low requests from external masters. Bit 0 is the bridge's grant input in external mode |
| br_req | input | 1 | Bridge wants the bus |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| gnt_n | output | 9 | Active-low grants to external masters. Bit 0 is the bridge's request output in external mode |
| br_gnt | output | 1 | Bridge holds the bus |
| park_drive | output | 1 | Enable for the bridge to drive address/data, command/byte-enable and parity while parked |
| sec_reset_n | output | 1 | Secondary bus reset, active low |

## Verification
The assertions assume that `strap_ext` changes only rarely, since the mode-dependent properties look at its value over two adjacent cycles. They also assume the reset inputs are synchronous to `clk`. The bus-activity inputs `frame_n` and `irdy_n` are treated as free inputs with no protocol ordering between them. The stimulus therefore drives them from a pseudo-random source together with dense and sparse request patterns. It changes the strap only in a few separate phases, and it asserts the software reset bit in isolated pulses.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic {
    MODE_INTERNAL = 1'b0,
    MODE_EXTERNAL = 1'b1
  } sbus_mode_e;

  localparam int unsigned SBUS_DEF_MASTERS = 9;
  localparam int unsigned SBUS_DEF_GAP     = 2;
endpackage

// File: rtl/sbus_gap_guard.sv
// Blocks a requester for GAP-1 cycles after its grant is withdrawn.
module sbus_gap_guard #(
  parameter int GAP = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic held,
  input  logic held_next,
  output logic block
);
  localparam int CW = $clog2(GAP + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)                   cnt <= '0;
    else if (held && !held_next) cnt <= CW'(GAP - 1);
    else if (cnt != '0)        cnt <= cnt - CW'(1);
  end

  assign block = (cnt != '0);
endmodule

// File: rtl/sbus_rr_pick.sv
// Round-robin search: first candidate after index 'last', wrapping.
module sbus_rr_pick #(
  parameter int N  = 10,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] last,
  output logic          hit,
  output logic [IW-1:0] win
);
  int j;

  always_comb begin
    hit = 1'b0;
    win = '0;
    j   = 0;
    for (int k = 1; k <= N; k++) begin
      j = (int'(last) + k) % N;
      if (!hit && cand[j]) begin
        hit = 1'b1;
        win = IW'(j);
      end
    end
  end
endmodule

// File: rtl/sbus_arbiter.sv
module sbus_arbiter
  import sbus_pkg::*;
#(
  parameter int N_EXT = SBUS_DEF_MASTERS,
  parameter int GAP   = SBUS_DEF_GAP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srst_ctl,
  input  logic             strap_ext,
  input  logic [N_EXT-1:0] req_n,
  input  logic             br_req,
  input  logic             frame_n,
  input  logic             irdy_n,
  output logic [N_EXT-1:0] gnt_n,
  output logic             br_gnt,
  output logic             park_drive,
  output logic             sec_reset_n
);
  localparam int NREQ = N_EXT + 1;
  localparam int BR   = N_EXT;
  localparam int IW   = $clog2(NREQ);

  sbus_mode_e      mode;
  logic            hold;
  logic            idle;
  logic [NREQ-1:0] want;
  logic [NREQ-1:0] block;
  logic [NREQ-1:0] cand;
  logic [NREQ-1:0] owner_q, owner_d;
  logic [IW-1:0]   last_q, last_d;
  logic            hit;
  logic [IW-1:0]   win;
  logic            owner_wants;
  logic            may_move;

  assign mode = strap_ext ? MODE_EXTERNAL : MODE_INTERNAL;
  assign hold = rst | srst_ctl;
  assign idle = frame_n & irdy_n;
  assign want = {br_req, ~req_n};
  assign cand = want & ~block;

  // one gap guard per requester
  for (genvar g = 0; g < NREQ; g++) begin : g_guard
    sbus_gap_guard #(.GAP(GAP)) u_guard (
      .clk      (clk),
      .clr      (hold),
      .held     (owner_q[g]),
      .held_next(owner_d[g]),
      .block    (block[g])
    );
  end

  sbus_rr_pick #(.N(NREQ), .IW(IW)) u_pick (
    .cand(cand),
    .last(last_q),
    .hit (hit),
    .win (win)
  );

  assign owner_wants = |(owner_q & want);
  assign may_move    = idle | ~owner_wants;

  always_comb begin
    owner_d = owner_q;
    last_d  = last_q;
    if (hold || mode == MODE_EXTERNAL) begin
      owner_d = '0;
    end else if (may_move) begin
      owner_d = '0;
      if (hit) begin
        owner_d[win] = 1'b1;
        last_d       = win;
      end else if (!block[BR]) begin
        owner_d[BR] = 1'b1;
        last_d      = IW'(BR);
      end
    end
  end

  always_ff @(posedge clk) begin
    sec_reset_n <= ~hold;
    if (hold) begin
      owner_q    <= '0;
      last_q     <= IW'(BR);
      gnt_n      <= '1;
      br_gnt     <= 1'b0;
      park_drive <= 1'b0;
    end else begin
      owner_q <= owner_d;
      last_q  <= last_d;
      if (mode == MODE_EXTERNAL) begin
        gnt_n      <= {{(N_EXT-1){1'b1}}, ~br_req};
        br_gnt     <= ~req_n[0];
        park_drive <= ~req_n[0] & idle;
      end else begin
        gnt_n      <= ~owner_d[N_EXT-1:0];
        br_gnt     <= owner_d[BR];
        park_drive <= owner_d[BR] & idle;
      end
    end
  end
endmodule

// File: rtl/sbus_arbiter_chk.sv
module sbus_arbiter_chk #(
  parameter int N_EXT = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             srst_ctl,
  input logic             strap_ext,
  input logic [N_EXT-1:0] req_n,
  input logic             br_req,
  input logic             frame_n,
  input logic             irdy_n,
  input logic [N_EXT-1:0] gnt_n,
  input logic             br_gnt,
  input logic             park_drive,
  input logic             sec_reset_n
);
  AST_SRST_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    sec_reset_n == !$past(rst || srst_ctl)); // R1

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst || srst_ctl) |-> (&gnt_n && !br_gnt && !park_drive)); // R2

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
    $past(!strap_ext) |-> $onehot0({~gnt_n, br_gnt})); // R3

  AST_PARK_NEEDS_GNT: assert property (@(posedge clk) disable iff (rst)
    park_drive |-> br_gnt); // R9

  AST_EXT_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(strap_ext) |-> &gnt_n[N_EXT-1:1]); // R8

  AST_BR_GAP: assert property (@(posedge clk) disable iff (rst)
    (!strap_ext && $past(!strap_ext) && $fell(br_gnt)) |=> !br_gnt); // R7

  AST_BR_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!strap_ext && $past(!strap_ext) && !srst_ctl && !(frame_n && irdy_n)
     && br_gnt && br_req) |=> br_gnt); // R5

  for (genvar i = 0; i < N_EXT; i++) begin : g_each
    AST_GNT_GAP: assert property (@(posedge clk) disable iff (rst)
      (!strap_ext && $past(!strap_ext) && $rose(gnt_n[i])) |=> gnt_n[i]); // R7

    AST_GNT_KEEP: assert property (@(posedge clk) disable iff (rst)
      (!strap_ext && $past(!strap_ext) && !srst_ctl && !(frame_n && irdy_n)
       && !gnt_n[i] && !req_n[i]) |=> !gnt_n[i]); // R5
  end
endmodule

bind sbus_arbiter sbus_arbiter_chk #(.N_EXT(N_EXT)) u_chk (
  .clk(clk), .rst(rst), .srst_ctl(srst_ctl), .strap_ext(strap_ext),
  .req_n(req_n), .br_req(br_req), .frame_n(frame_n), .irdy_n(irdy_n),
  .gnt_n(gnt_n), .br_gnt(br_gnt), .park_drive(park_drive),
  .sec_reset_n(sec_reset_n)
);

// File: tb/sim_sbus_arbiter.sv
module sim_sbus_arbiter;
  localparam int NE  = 9;
  localparam int NR  = NE + 1;
  localparam int GAP = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          srst_ctl = 1'b0;
  logic          strap_ext = 1'b0;
  logic [NE-1:0] req_n = '1;
  logic          br_req = 1'b0;
  logic          frame_n = 1'b1;
  logic          irdy_n = 1'b1;
  logic [NE-1:0] gnt_n;
  logic          br_gnt;
  logic          park_drive;
  logic          sec_reset_n;

  always #5 clk = ~clk;

  sbus_arbiter #(.N_EXT(NE), .GAP(GAP)) u0 (
    .clk(clk), .rst(rst), .srst_ctl(srst_ctl), .strap_ext(strap_ext),
    .req_n(req_n), .br_req(br_req), .frame_n(frame_n), .irdy_n(irdy_n),
    .gnt_n(gnt_n), .br_gnt(br_gnt), .park_drive(park_drive),
    .sec_reset_n(sec_reset_n)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state
  int            m_own  = -1;
  int            m_last = NE;
  int            m_cool[NR];
  logic [NE-1:0] e_gnt_n;
  logic          e_br, e_park, e_srn;
  bit            e_hold, e_ext;
  int            offrun[NR];
  bit            prev_on[NR];
  logic [31:0]   seed = 32'h1234_5678;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic model_edge();
    bit hold, idl, mv;
    bit rq[NR];
    int nown, nlast;
    hold = rst || srst_ctl;
    idl  = frame_n && irdy_n;
    for (int i = 0; i < NE; i++) rq[i] = !req_n[i];
    rq[NE] = br_req;
    nown  = m_own;
    nlast = m_last;
    e_hold = hold;
    e_ext  = strap_ext;
    e_srn  = !hold;
    if (hold) begin
      nown = -1;
      nlast = NE;
      for (int i = 0; i < NR; i++) m_cool[i] = 0;
      e_gnt_n = '1; e_br = 0; e_park = 0;
    end else begin
      if (strap_ext) begin
        nown = -1;
      end else begin
        mv = idl || (m_own < 0) || !rq[m_own];
        if (mv) begin
          nown = -2;
          for (int k = 1; k <= NR; k++) begin
            int j;
            j = (m_last + k) % NR;
            if (nown == -2 && rq[j] && m_cool[j] == 0) nown = j;
          end
          if (nown == -2) nown = (m_cool[NE] == 0) ? NE : -1;
          if (nown >= 0) nlast = nown;
        end
      end
      for (int i = 0; i < NR; i++) begin
        if (m_own == i && nown != i) m_cool[i] = GAP - 1;
        else if (m_cool[i] > 0)      m_cool[i] = m_cool[i] - 1;
      end
      if (strap_ext) begin
        e_gnt_n = '1;
        e_gnt_n[0] = !br_req;
        e_br = !req_n[0];
      end else begin
        for (int i = 0; i < NE; i++) e_gnt_n[i] = !(nown == i);
        e_br = (nown == NE);
      end
      e_park = e_br && idl;
    end
    m_own  = nown;
    m_last = nlast;
  endtask

  task automatic compare();
    int ones;
    bit on;
    check(sec_reset_n === e_srn, "R1 sec_reset_n", sec_reset_n, e_srn);
    if (e_hold) begin
      check(gnt_n === e_gnt_n && br_gnt === e_br && park_drive === e_park,
            "R2 quiet during reset", {gnt_n, br_gnt, park_drive}, {e_gnt_n, e_br, e_park});
    end else if (e_ext) begin
      check(gnt_n === e_gnt_n, "R8 ext gnt_n", gnt_n, e_gnt_n);
      check(br_gnt === e_br, "R8 ext br_gnt", br_gnt, e_br);
    end else begin
      check(gnt_n === e_gnt_n, "R4 R5 R6 gnt_n", gnt_n, e_gnt_n);
      check(br_gnt === e_br, "R4 R5 R6 br_gnt", br_gnt, e_br);
      ones = 0;
      for (int i = 0; i < NE; i++) ones += (gnt_n[i] == 1'b0) ? 1 : 0;
      ones += br_gnt ? 1 : 0;
      check(ones <= 1, "R3 one owner", ones, 1);
    end
    check(park_drive === e_park, "R9 park_drive", park_drive, e_park);
    // gap tracking from the outputs alone
    for (int i = 0; i < NR; i++) begin
      on = (i < NE) ? (gnt_n[i] == 1'b0) : (br_gnt == 1'b1);
      if (e_hold || e_ext) begin
        offrun[i] = 99; prev_on[i] = 0;
      end else begin
        if (on && !prev_on[i]) check(offrun[i] >= GAP, "R7 grant gap", offrun[i], GAP);
        offrun[i] = on ? 0 : offrun[i] + 1;
        prev_on[i] = on;
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic rand_inputs(input bit dense);
    seed = nxt(seed);
    frame_n = seed[0] | seed[1];
    irdy_n  = seed[2] | seed[3];
    if (dense) req_n = seed[12:4] & seed[21:13];
    else       req_n = seed[12:4] | seed[21:13];
    br_req = dense ? (seed[22] | seed[23]) : (seed[22] & seed[23]);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) begin m_cool[i] = 0; offrun[i] = 99; prev_on[i] = 0; end
    @(negedge clk);
    for (int n = 0; n < 3; n++) step();           // R2 reset state
    rst = 1'b0;
    // all requesting on an idle bus: rotation 0..9 (R4)
    req_n = '0; br_req = 1'b1;
    for (int n = 0; n < 30; n++) step();
    // nobody requesting: park on bridge (R6)
    req_n = '1; br_req = 1'b0;
    for (int n = 0; n < 5; n++) step();
    check(br_gnt === 1'b1, "R6 parked on bridge", br_gnt, 1);
    // busy bus with owner holding request (R5)
    req_n = '1; req_n[4] = 1'b0;
    for (int n = 0; n < 4; n++) step();
    frame_n = 1'b0; irdy_n = 1'b0; req_n[2] = 1'b0;
    for (int n = 0; n < 6; n++) step();
    check(gnt_n[4] === 1'b0, "R5 owner kept while busy", gnt_n[4], 0);
    frame_n = 1'b1; irdy_n = 1'b1; req_n = '1;
    // random sweeps
    for (int n = 0; n < 1500; n++) begin rand_inputs(n[6]); step(); end
    srst_ctl = 1'b1;
    for (int n = 0; n < 3; n++) begin rand_inputs(1); step(); end
    srst_ctl = 1'b0;
    for (int n = 0; n < 300; n++) begin rand_inputs(n[4]); step(); end
    strap_ext = 1'b1;
    for (int n = 0; n < 300; n++) begin rand_inputs(n[3]); step(); end
    strap_ext = 1'b0;
    for (int n = 0; n < 500; n++) begin rand_inputs(n[5]); step(); end
    rst = 1'b1;
    step();
    check(sec_reset_n === 1'b0, "R1 primary reset", sec_reset_n, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R10 actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule